// File: doc/BRIEF.md
# SD Card Command Line Engine

This block owns the CMD wire of an SD card port. When asked, it serialises a 48-bit command frame from a 6-bit index and a 32-bit argument, with the CRC7 worked out in hardware. It can then release the line, listen for the card's reply, and capture either a 48-bit short reply or a 136-bit long reply. The reply's CRC7 is checked in every case. The engine also produces the two plain clock bursts a card needs: the long power-up run and the short trailing run. It gives up on a silent card after a programmable number of cycles.

Every system clock cycle in which `sd_clk_en` is high is one SD clock period. Dividing the clock and gating it are left to the surrounding logic. Software-style control is reduced to one-cycle start strobes and pending and status levels. The pending levels drop by themselves when their operation ends, and `done` pulses once at that moment. A soft reset stops any operation at once. It leaves the captured reply and every configuration input untouched.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, all pending outputs, `cmd_oe` and all status flags are 0, `cmd_out` is 1 and `sd_clk_en` follows `clk_keep`.
- R2: A command is 48 bits sent MSB first: 0, 1, the 6-bit index, the 32-bit argument, a CRC7 over those first 40 bits (x^7+x^3+1, register cleared to zero), then 1. Bit k is on `cmd_out` with `cmd_oe` high during the k-th cycle after the edge that accepts `cmd_go`.
- R3: `send_pend` is high exactly while frame bits are driven. `resp_pend` rises with a command that asked for a reply and falls when that reply completes, times out or is cancelled. `clks_pend` covers a clock burst. `done` pulses for one cycle when any operation ends.
- R4: `init_go` gives exactly INIT_CLKS (74) cycles of `sd_clk_en`, and `trail_go` gives exactly TRAIL_CLKS (8). During both, `cmd_out` is held at 1 and driven.
- R5: In a 48-bit reply the first received bit is bit 47. Bits 47..16 appear on `rsp_word` and bits 15..8 on `rsp_tail`.
- R6: In a 136-bit reply the first received bit is bit 135. Bits 127..8 appear on `rsp_long_data`, so the CRC7, the end bit and the 8 leading bits are dropped.
- R7: A reply's CRC7 is recomputed over bits 47..8 (short) or 127..8 (long) and compared with the 7 bits before its end bit. A match sets `crc_ok`. A mismatch clears `crc_ok` and sets `crc_err`, whatever the reply type. Both flags clear when the next command is accepted.
- R8: For GAP_CYC (2) cycles after the end bit, `cmd_in` is ignored. The first low sample after that is taken as the reply's start bit.
- R9: While waiting for a start bit, `tmo_limit` consecutive high samples set `tmo_flag`, pulse `done` and return the engine to idle. A limit of 0 waits indefinitely.
- R10: `soft_rst` returns the engine to idle on the next cycle and clears `send_pend`, `resp_pend` and `cmd_oe`. The captured reply outputs keep their values.
- R11: `sd_clk_en` is high whenever the engine is busy or `clk_keep` is set, and low when it is idle with `clk_keep` clear.
- R12: Start strobes are ignored while busy. When strobes coincide in an idle cycle, `init_go` wins over `cmd_go`, which wins over `trail_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one SD clock period per enabled cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Abort the current operation, keep captured data |
| clk_keep | input | 1 | Keep the SD clock running while idle |
| cmd_go | input | 1 | Start a command |
| init_go | input | 1 | Start the power-up clock burst |
| trail_go | input | 1 | Start the trailing clock burst |
| rsp_want | input | 1 | The command expects a reply |
| rsp_long | input | 1 | The expected reply is 136 bits |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| tmo_limit | input | TMO_W | Start-bit wait limit in cycles, 0 means none |
| cmd_in | input | 1 | CMD line as seen from the card side |
| cmd_out | output | 1 | CMD line value to drive |
| cmd_oe | output | 1 | CMD line drive enable |
| sd_clk_en | output | 1 | SD clock gate enable |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation ends |
| send_pend | output | 1 | Command frame is being sent |
| resp_pend | output | 1 | A reply is requested and not yet finished |
| clks_pend | output | 1 | A clock burst is running |
| rsp_word | output | 32 | Short reply bits 47..16 |
| rsp_tail | output | 8 | Short reply bits 15..8 |
| rsp_long_data | output | 120 | Long reply bits 127..8 |
| crc_ok | output | 1 | Last reply CRC7 matched |
| crc_err | output | 1 | Last reply CRC7 mismatched |
| tmo_flag | output | 1 | Last reply wait timed out |

## Verification
The bench builds the engine with its defaults: a 24-bit timeout, bursts of 74 and 8 cycles, a 2-cycle turnaround gap and long-reply support enabled. Enabling long replies puts the 136-bit capture path and its shifted CRC window within reach. Because the wait limit is a port, the bench can drive limits of a few cycles, which makes the exact expiry cycle observable, and can also drive zero to show an endless wait. A card model answers after random turnaround delays with random contents and occasional corrupted CRCs, and in one case pulls the line low inside the ignored gap.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
   localparam int CMD_LEN     = 48;
   localparam int SHORT_LEN   = 48;
   localparam int LONG_LEN    = 136;
   localparam int LONG_DATA_W = 120;
   localparam int IDX_W       = 6;
   localparam int ARG_W       = 32;
   localparam int BODY_W      = 2 + IDX_W + ARG_W;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SEND, ST_GAP, ST_WAIT, ST_RECV, ST_CLKS
   } eng_state_t;

   // one serial step of the x^7+x^3+1 checksum
   function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
      logic fb;
      fb = b ^ c[6];
      return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
   endfunction

   function automatic logic [6:0] crc7_body(input logic [BODY_W-1:0] d);
      logic [6:0] c;
      c = '0;
      for (int i = BODY_W - 1; i >= 0; i--) c = crc7_step(c, d[i]);
      return c;
   endfunction
endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
   import sdcmd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic [IDX_W-1:0] idx,
   input  logic [ARG_W-1:0] arg,
   output logic             bit_out
);
   logic [CMD_LEN-1:0] sh_q;
   logic [BODY_W-1:0]  body;

   assign body = {2'b01, idx, arg};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sh_q <= '1;
      else if (load)   sh_q <= {body, crc7_body(body), 1'b1};
      else if (shift)  sh_q <= {sh_q[CMD_LEN-2:0], 1'b1};
   end

   assign bit_out = sh_q[CMD_LEN-1];
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
   import sdcmd_pkg::*;
#(
   parameter bit LONG_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   first,
   input  logic                   shift,
   input  logic                   bit_in,
   input  logic                   long_sel,
   output logic                   last,
   output logic                   crc_match,
   output logic [31:0]            word,
   output logic [7:0]             tail,
   output logic [LONG_DATA_W-1:0] long_data
);
   localparam int SH_W  = LONG_EN ? LONG_LEN : SHORT_LEN;
   localparam int POS_W = $clog2(LONG_LEN + 1);
   localparam logic [POS_W-1:0] P_SHORT_END = POS_W'(SHORT_LEN - 9);
   localparam logic [POS_W-1:0] P_LONG_BEG  = POS_W'(LONG_LEN - 128);
   localparam logic [POS_W-1:0] P_LONG_END  = POS_W'(LONG_LEN - 9);
   localparam logic [POS_W-1:0] P_SHORT_LST = POS_W'(SHORT_LEN - 1);
   localparam logic [POS_W-1:0] P_LONG_LST  = POS_W'(LONG_LEN - 1);

   logic [SH_W-1:0]  sh_q;
   logic [POS_W-1:0] pos_q, pos_now;
   logic [6:0]       crc_q, crc_base;
   logic             is_long, covered;

   assign is_long  = LONG_EN && long_sel;
   assign pos_now  = first ? '0 : pos_q;
   assign crc_base = first ? '0 : crc_q;

   always_comb begin
      if (is_long) covered = (pos_now >= P_LONG_BEG) && (pos_now <= P_LONG_END);
      else         covered = (pos_now <= P_SHORT_END);
   end

   assign last      = shift && (pos_now == (is_long ? P_LONG_LST : P_SHORT_LST));
   assign crc_match = (sh_q[6:0] == crc_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         pos_q <= '0;
         crc_q <= '0;
      end else if (shift) begin
         sh_q  <= {sh_q[SH_W-2:0], bit_in};
         pos_q <= pos_now + 1'b1;
         crc_q <= covered ? crc7_step(crc_base, bit_in) : crc_base;
      end
   end

   assign word = sh_q[47:16];
   assign tail = sh_q[15:8];

   generate
      if (LONG_EN) begin : g_long
         assign long_data = sh_q[127:8];
      end else begin : g_short_only
         assign long_data = '0;
      end
   endgenerate
endmodule

// File: rtl/sdcmd_tmo.sv
module sdcmd_tmo #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         expire
);
   logic [W-1:0] cnt_q;

   assign expire = run && (limit != '0) && (cnt_q == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!run)  cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
   import sdcmd_pkg::*;
#(
   parameter int TMO_W      = 24,
   parameter int INIT_CLKS  = 74,
   parameter int TRAIL_CLKS = 8,
   parameter int GAP_CYC    = 2,
   parameter bit LONG_EN    = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   soft_rst,
   input  logic                   clk_keep,
   input  logic                   cmd_go,
   input  logic                   init_go,
   input  logic                   trail_go,
   input  logic                   rsp_want,
   input  logic                   rsp_long,
   input  logic [5:0]             cmd_idx,
   input  logic [31:0]            cmd_arg,
   input  logic [TMO_W-1:0]       tmo_limit,
   input  logic                   cmd_in,
   output logic                   cmd_out,
   output logic                   cmd_oe,
   output logic                   sd_clk_en,
   output logic                   busy,
   output logic                   done,
   output logic                   send_pend,
   output logic                   resp_pend,
   output logic                   clks_pend,
   output logic [31:0]            rsp_word,
   output logic [7:0]             rsp_tail,
   output logic [119:0]           rsp_long_data,
   output logic                   crc_ok,
   output logic                   crc_err,
   output logic                   tmo_flag
);
   localparam int MAX_A   = (INIT_CLKS > TRAIL_CLKS) ? INIT_CLKS : TRAIL_CLKS;
   localparam int MAX_B   = (CMD_LEN > GAP_CYC) ? CMD_LEN : GAP_CYC;
   localparam int MAX_SEQ = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W   = $clog2(MAX_SEQ + 1);
   localparam logic [CNT_W-1:0] INIT_LOAD  = CNT_W'(INIT_CLKS - 1);
   localparam logic [CNT_W-1:0] TRAIL_LOAD = CNT_W'(TRAIL_CLKS - 1);
   localparam logic [CNT_W-1:0] CMD_LOAD   = CNT_W'(CMD_LEN - 1);
   localparam logic [CNT_W-1:0] GAP_LOAD   = CNT_W'(GAP_CYC - 1);

   generate
      if (TMO_W < 1 || TMO_W > 32) begin : g_bad_tmo
         $error("sdcmd_engine: TMO_W must lie in 1..32");
      end
      if (INIT_CLKS < 1 || TRAIL_CLKS < 1) begin : g_bad_burst
         $error("sdcmd_engine: clock bursts need at least one cycle");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("sdcmd_engine: GAP_CYC must be at least 1");
      end
   endgenerate

   eng_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             want_q, long_q, done_q, crc_ok_q, crc_err_q, tmo_q;
   logic             tx_load, tx_bit, rx_first, rx_shift, rx_last, rx_match;
   logic             tmo_run, tmo_expire;

   assign tx_load  = (state_q == ST_IDLE) && !soft_rst && !init_go && cmd_go;
   assign rx_first = (state_q == ST_WAIT) && !soft_rst && !cmd_in;
   assign rx_shift = rx_first || ((state_q == ST_RECV) && !soft_rst);
   assign tmo_run  = (state_q == ST_WAIT) && cmd_in;

   sdcmd_tx u_tx (
      .clk(clk), .rst_n(rst_n), .load(tx_load), .shift(state_q == ST_SEND),
      .idx(cmd_idx), .arg(cmd_arg), .bit_out(tx_bit)
   );

   sdcmd_rx #(.LONG_EN(LONG_EN)) u_rx (
      .clk(clk), .rst_n(rst_n), .first(rx_first), .shift(rx_shift), .bit_in(cmd_in),
      .long_sel(long_q), .last(rx_last), .crc_match(rx_match),
      .word(rsp_word), .tail(rsp_tail), .long_data(rsp_long_data)
   );

   sdcmd_tmo #(.W(TMO_W)) u_tmo (
      .clk(clk), .rst_n(rst_n), .run(tmo_run), .limit(tmo_limit), .expire(tmo_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         want_q    <= 1'b0;
         long_q    <= 1'b0;
         done_q    <= 1'b0;
         crc_ok_q  <= 1'b0;
         crc_err_q <= 1'b0;
         tmo_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (soft_rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            want_q  <= 1'b0;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  if (init_go) begin
                     state_q <= ST_CLKS;
                     cnt_q   <= INIT_LOAD;
                  end else if (cmd_go) begin
                     state_q   <= ST_SEND;
                     cnt_q     <= CMD_LOAD;
                     want_q    <= rsp_want;
                     long_q    <= rsp_long;
                     crc_ok_q  <= 1'b0;
                     crc_err_q <= 1'b0;
                     tmo_q     <= 1'b0;
                  end else if (trail_go) begin
                     state_q <= ST_CLKS;
                     cnt_q   <= TRAIL_LOAD;
                  end
               end
               ST_SEND: begin
                  if (cnt_q == '0) begin
                     if (want_q) begin
                        state_q <= ST_GAP;
                        cnt_q   <= GAP_LOAD;
                     end else begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end
                  end else cnt_q <= cnt_q - 1'b1;
               end
               ST_GAP: begin
                  if (cnt_q == '0) state_q <= ST_WAIT;
                  else             cnt_q   <= cnt_q - 1'b1;
               end
               ST_WAIT: begin
                  if (!cmd_in) state_q <= ST_RECV;
                  else if (tmo_expire) begin
                     state_q <= ST_IDLE;
                     tmo_q   <= 1'b1;
                     done_q  <= 1'b1;
                     want_q  <= 1'b0;
                  end
               end
               ST_RECV: begin
                  if (rx_last) begin
                     state_q   <= ST_IDLE;
                     done_q    <= 1'b1;
                     want_q    <= 1'b0;
                     crc_ok_q  <= rx_match;
                     crc_err_q <= !rx_match;
                  end
               end
               ST_CLKS: begin
                  if (cnt_q == '0) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else cnt_q <= cnt_q - 1'b1;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign send_pend = (state_q == ST_SEND);
   assign clks_pend = (state_q == ST_CLKS);
   assign resp_pend = want_q;
   assign cmd_oe    = (state_q == ST_SEND) || (state_q == ST_CLKS);
   assign cmd_out   = (state_q == ST_SEND) ? tx_bit : 1'b1;
   assign sd_clk_en = clk_keep || busy;
   assign done      = done_q;
   assign crc_ok    = crc_ok_q;
   assign crc_err   = crc_err_q;
   assign tmo_flag  = tmo_q;
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic soft_rst,
   input logic cmd_out,
   input logic cmd_oe,
   input logic sd_clk_en,
   input logic busy,
   input logic done,
   input logic send_pend,
   input logic resp_pend,
   input logic clks_pend,
   input logic crc_ok,
   input logic crc_err,
   input logic tmo_flag
);
   a_r3_resp_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      resp_pend |-> busy);

   a_r3_burst_alone: assert property (@(posedge clk) disable iff (!rst_n)
      clks_pend |-> (!send_pend && !resp_pend));

   a_r3_send_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(send_pend) |-> (resp_pend || done || $past(soft_rst)));

   a_r4_burst_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      clks_pend |-> (cmd_out && cmd_oe));

   a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_err) |-> (done && !crc_ok));

   a_r9_tmo_ends_op: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> (done && !busy));

   a_r10_soft_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!busy && !resp_pend));

   a_r11_clock_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> sd_clk_en);
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
   .sd_clk_en(sd_clk_en), .busy(busy), .done(done), .send_pend(send_pend),
   .resp_pend(resp_pend), .clks_pend(clks_pend), .crc_ok(crc_ok), .crc_err(crc_err),
   .tmo_flag(tmo_flag)
);

// File: tb/tb_sdcmd_engine.sv
module tb_sdcmd_engine;
   logic         clk = 1'b0;
   logic         rst_n, soft_rst, clk_keep, cmd_go, init_go, trail_go, rsp_want, rsp_long;
   logic [5:0]   cmd_idx;
   logic [31:0]  cmd_arg;
   logic [23:0]  tmo_limit;
   logic         cmd_in;
   logic         cmd_out, cmd_oe, sd_clk_en, busy, done, send_pend, resp_pend, clks_pend;
   logic [31:0]  rsp_word;
   logic [7:0]   rsp_tail;
   logic [119:0] rsp_long_data;
   logic         crc_ok, crc_err, tmo_flag;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   sdcmd_engine dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clk_keep(clk_keep), .cmd_go(cmd_go),
      .init_go(init_go), .trail_go(trail_go), .rsp_want(rsp_want), .rsp_long(rsp_long),
      .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .tmo_limit(tmo_limit), .cmd_in(cmd_in),
      .cmd_out(cmd_out), .cmd_oe(cmd_oe), .sd_clk_en(sd_clk_en), .busy(busy), .done(done),
      .send_pend(send_pend), .resp_pend(resp_pend), .clks_pend(clks_pend),
      .rsp_word(rsp_word), .rsp_tail(rsp_tail), .rsp_long_data(rsp_long_data),
      .crc_ok(crc_ok), .crc_err(crc_err), .tmo_flag(tmo_flag)
   );

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // reference checksum: n bits taken from v, highest first
   function automatic logic [6:0] ref_crc(input logic [119:0] v, input int n);
      logic [6:0] r;
      r = '0;
      for (int i = n - 1; i >= 0; i--) begin
         logic top;
         top  = r[6] ^ v[i];
         r    = r << 1;
         r[0] = top;
         r[3] = r[3] ^ top;
      end
      return r;
   endfunction

   // R2 R5 R6 R7 R8: one command with an optional card reply
   task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic want,
                          input logic lng, input int dly, input logic corrupt,
                          input logic gap_noise);
      logic [47:0]  exp_frame, got;
      logic [135:0] rf;
      logic [127:0] r128;
      logic         oe_ok;
      int           rlen;
      exp_frame = {2'b01, idx, arg, ref_crc({80'b0, 2'b01, idx, arg}, 40), 1'b1};
      r128 = {$urandom, $urandom, $urandom, $urandom};
      if (lng) begin
         rlen = 136;
         rf = {8'h3F, r128[119:0], 8'h01};
         rf[7:1] = ref_crc(rf[127:8], 120);
      end else begin
         rlen = 48;
         rf = '0;
         rf[47:0] = {2'b00, r128[37:0], 8'h01};
         rf[7:1] = ref_crc({80'b0, rf[47:8]}, 40);
      end
      if (corrupt) rf[1] = ~rf[1];

      @(negedge clk);
      cmd_idx = idx; cmd_arg = arg; rsp_want = want; rsp_long = lng; cmd_go = 1'b1;
      @(negedge clk);
      cmd_go = 1'b0;
      got = '0; oe_ok = 1'b1;
      for (int k = 0; k < 48; k++) begin
         if (k > 0) @(negedge clk);
         got = {got[46:0], cmd_out};
         if (!cmd_oe || !send_pend) oe_ok = 1'b0;
      end
      chk("R2", "command frame", got, exp_frame);
      chk("R3", "send_pend and cmd_oe during frame", oe_ok, 1'b1);
      chk("R7", "crc_err cleared at command start", crc_err, 1'b0);
      @(negedge clk);
      chk("R3", "send_pend falls after end bit", send_pend, 1'b0);
      if (!want) begin
         chk("R3", "done after command without reply", {done, busy, resp_pend}, 3'b100);
      end else begin
         chk("R3", "resp_pend while waiting", resp_pend, 1'b1);
         for (int n = 0; n < dly + rlen; n++) begin
            if (n > 0) @(negedge clk);
            if (n < dly) cmd_in = (gap_noise && n < 2) ? 1'b0 : 1'b1;
            else         cmd_in = rf[rlen - 1 - (n - dly)];
         end
         @(negedge clk);
         cmd_in = 1'b1;
         chk("R3", "done/busy/resp_pend after reply", {done, busy, resp_pend}, 3'b100);
         if (lng) chk("R6", "long reply payload", rsp_long_data, rf[127:8]);
         else begin
            chk("R5", "short reply word", rsp_word, rf[47:16]);
            chk("R5", "short reply tail", rsp_tail, rf[15:8]);
         end
         chk("R7", "crc_ok/crc_err", {crc_ok, crc_err}, {~corrupt, corrupt});
         if (gap_noise) chk("R8", "low inside gap ignored, reply intact", rsp_word, rf[47:16]);
      end
   endtask

   // R4 R12: one clock burst, optionally poking cmd_go while it runs
   task automatic run_burst(input logic long_one, input int exp_len, input logic poke);
      int   cnt;
      logic line_ok;
      @(negedge clk);
      if (long_one) init_go = 1'b1; else trail_go = 1'b1;
      @(negedge clk);
      init_go = 1'b0; trail_go = 1'b0;
      cnt = 0; line_ok = 1'b1;
      while (sd_clk_en && cnt < 1000) begin
         cnt++;
         if (!cmd_out || !cmd_oe || !clks_pend) line_ok = 1'b0;
         cmd_go = poke && (cnt == 5);
         @(negedge clk);
      end
      cmd_go = 1'b0;
      chk("R4", "burst length", cnt, exp_len);
      chk("R4", "line held high during burst", line_ok, 1'b1);
      chk("R3", "done at burst end", done, 1'b1);
      if (poke) begin
         @(negedge clk);
         chk("R12", "cmd_go ignored while busy", {busy, send_pend}, 2'b00);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] kept_word;
      void'($urandom(32'd7719));
      rst_n = 1'b0; soft_rst = 1'b0; clk_keep = 1'b0; cmd_go = 1'b0; init_go = 1'b0;
      trail_go = 1'b0; rsp_want = 1'b0; rsp_long = 1'b0; cmd_idx = '0; cmd_arg = '0;
      tmo_limit = 24'd1000; cmd_in = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "idle outputs", {busy, done, send_pend, resp_pend, clks_pend, cmd_oe, cmd_out},
          7'b0000001);
      chk("R1", "flags", {crc_ok, crc_err, tmo_flag}, 3'b000);
      chk("R11", "clock gated while idle", sd_clk_en, 1'b0);
      clk_keep = 1'b1;
      @(negedge clk);
      chk("R11", "clk_keep runs clock while idle", sd_clk_en, 1'b1);
      clk_keep = 1'b0;

      // R4 bursts, R12 busy ignore
      run_burst(1'b1, 74, 1'b0);
      run_burst(1'b0, 8, 1'b1);

      // R12 priority with all strobes together
      @(negedge clk);
      init_go = 1'b1; cmd_go = 1'b1; trail_go = 1'b1; rsp_want = 1'b1;
      @(negedge clk);
      init_go = 1'b0; cmd_go = 1'b0; trail_go = 1'b0;
      chk("R12", "init wins priority", {clks_pend, send_pend, resp_pend}, 3'b100);
      begin
         int cnt;
         cnt = 0;
         while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
         chk("R12", "winning burst is the long one", cnt, 74);
      end
      @(negedge clk);
      trail_go = 1'b1; cmd_go = 1'b1;
      @(negedge clk);
      trail_go = 1'b0; cmd_go = 1'b0;
      chk("R12", "command wins over trail burst", {send_pend, clks_pend}, 2'b10);
      @(negedge clk); soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;

      // directed corners
      run_cmd(6'h00, 32'h0000_0000, 1'b0, 1'b0, 2, 1'b0, 1'b0);
      run_cmd(6'h3F, 32'hFFFF_FFFF, 1'b1, 1'b0, 2, 1'b0, 1'b0);
      run_cmd(6'h11, 32'h1234_5678, 1'b1, 1'b1, 3, 1'b0, 1'b0);
      run_cmd(6'h29, 32'h00FF_8000, 1'b1, 1'b0, 4, 1'b1, 1'b0);
      run_cmd(6'h02, 32'hDEAD_BEEF, 1'b1, 1'b1, 2, 1'b1, 1'b0);
      run_cmd(6'h0D, 32'hA5A5_5A5A, 1'b1, 1'b0, 5, 1'b0, 1'b1);

      // constrained random traffic
      for (int it = 0; it < 24; it++) begin
         run_cmd(6'($urandom % 64), $urandom, ($urandom % 4) != 0, 1'($urandom % 2),
                 2 + int'($urandom % 5), ($urandom % 4) == 0, 1'b0);
      end

      // R9 timeout after exactly tmo_limit high samples
      for (int lim = 1; lim <= 5; lim += 4) begin
         tmo_limit = 24'(lim);
         @(negedge clk);
         cmd_idx = 6'h08; cmd_arg = 32'h1AA; rsp_want = 1'b1; rsp_long = 1'b0; cmd_go = 1'b1;
         @(negedge clk);
         cmd_go = 1'b0;
         repeat (48) @(negedge clk);
         for (int n = 1; n <= lim + 1; n++) @(negedge clk);
         chk("R9", "no timeout one cycle early", {tmo_flag, busy}, 2'b01);
         @(negedge clk);
         chk("R9", "timeout flag, done, idle", {tmo_flag, done, busy, resp_pend}, 4'b1100);
      end

      // R9 zero limit waits, R10 soft reset recovers and keeps data
      kept_word = rsp_word;
      tmo_limit = 24'd0;
      @(negedge clk);
      cmd_go = 1'b1; rsp_want = 1'b1;
      @(negedge clk);
      cmd_go = 1'b0;
      repeat (300) @(negedge clk);
      chk("R9", "zero limit still waiting", {busy, resp_pend, tmo_flag}, 3'b110);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      chk("R10", "soft reset from wait", {busy, resp_pend, cmd_oe}, 3'b000);
      chk("R10", "reply word kept", rsp_word, kept_word);

      tmo_limit = 24'd1000;
      @(negedge clk);
      cmd_go = 1'b1; rsp_want = 1'b1;
      @(negedge clk);
      cmd_go = 1'b0;
      repeat (10) @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      chk("R10", "soft reset mid frame", {busy, send_pend, resp_pend, cmd_oe, cmd_out}, 5'b00001);
      chk("R11", "clock gated after soft reset", sd_clk_en, 1'b0);
      run_cmd(6'h37, 32'h0BAD_F00D, 1'b1, 1'b0, 3, 1'b0, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule